// File: doc/BRIEF.md
# Area-Decoding External Bus Controller

This block sits between a CPU core and an external asynchronous memory bus with a 24-bit address space. It splits that space into eight equal 2 MB areas, takes the top three address bits as the area number, and drives the matching active-low chip select for the whole access. Each access runs as a first state, any number of wait states, and a last state. The address strobe, the read strobe and the two byte-lane write strobes stay asserted across all of these states.

Each area has its own settings. One bit picks an 8-bit or a 16-bit data bus. A 2-bit field sets a programmed wait count from 0 to 3. A third bit lets the external WAIT pin stretch the access beyond the programmed count. Software loads these settings through a small write port with three register selects.

An external master can take the bus with a request/grant handshake. The controller finishes any access in progress, stops driving the strobes, the address and the data, and raises the grant. A CPU request that arrives while the bus is given away waits until the grant is withdrawn.

Top module: `xbus_area_ctrl`

## Requirements
- R1: While an access is in progress, exactly one chip select is low: cs_n[k], where k = address bits 23..21. When no access is in progress, all eight chip selects are high.
- R2: On a read, as_n, rd_n and the chip select go low in the same cycles and rise in the same cycle. hwr_n and lwr_n stay high. On a write, rd_n stays high.
- R3: A word write (req_word=1) to an even address in a 16-bit area pulls both hwr_n and lwr_n low for the whole access. bus_dout equals req_wdata and dout_oe is 2'b11 (bit 1 is the upper lane D15..D8, bit 0 is the lower lane D7..D0).
- R4: In a 16-bit area, a byte access (req_word=0) to an even address, or any access to an odd address, uses one lane only. An even address uses the upper lane (hwr_n, D15..D8) and an odd address uses the lower lane (lwr_n, D7..D0). Byte data is taken from req_wdata[7:0]. In an 8-bit area every access uses only the upper lane and hwr_n, and lwr_n never goes low.
- R5: With pin wait not in effect, as_n stays low for exactly 2+N consecutive cycles. N is the 2-bit wait field of area k, held in bits [2k+1:2k] of the wait register.
- R6: When the pin-wait bit of area k is set and the N programmed waits have elapsed, a further wait state is added for each rising edge that ends the first state or a wait state and finds wait_n low. When that bit is clear, wait_n has no effect.
- R7: req_done is high for exactly one cycle, the cycle after the last strobe cycle, and req_rdata is valid in that cycle. A 16-bit-area word read at an even address returns bus_din. A single-lane read returns the selected lane zero-extended: the upper lane is {8'h00, bus_din[15:8]} and the lower lane is {8'h00, bus_din[7:0]}.
- R8: When breq_n is low and no access is in progress, back_n goes low in the next cycle. While back_n is low, ctl_oe, addr_oe and dout_oe are all 0. If breq_n falls during an access, back_n stays high until that access has completed.
- R9: A request that arrives while back_n is low starts no access. When breq_n goes high, back_n rises in the next cycle, and only after that does the waiting request run.
- R10: After reset, every area is 8-bit, every wait field is 3 and every pin-wait bit is clear. All chip selects and strobes are high, back_n is high, and ctl_oe and addr_oe are 1.
- R11: When cfg_we is 1, cfg_sel chooses the register that cfg_wdata loads. Select 0 loads the width bits (bit k = 1 makes area k 16-bit). Select 1 loads the 16-bit wait register. Select 2 loads the pin-wait enable bits (bit k). A write with select 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | CPU access request, held until req_done |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| req_addr | input | 24 | Byte address |
| req_wdata | input | 16 | Write data (a byte access uses bits 7..0) |
| req_done | output | 1 | One-cycle completion pulse |
| req_rdata | output | 16 | Read data, valid while req_done is high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 width, 1 wait, 2 pin-wait, 3 none |
| cfg_wdata | input | 16 | Configuration write data |
| cs_n | output | 8 | Active-low area chip selects |
| as_n | output | 1 | Active-low address strobe |
| rd_n | output | 1 | Active-low read strobe |
| hwr_n | output | 1 | Active-low upper-lane write strobe |
| lwr_n | output | 1 | Active-low lower-lane write strobe |
| ctl_oe | output | 1 | Drive enable for as_n, rd_n, hwr_n and lwr_n |
| bus_addr | output | 24 | External address |
| addr_oe | output | 1 | Address drive enable |
| bus_dout | output | 16 | External write data |
| dout_oe | output | 2 | Data drive enable per lane (bit 1 upper, bit 0 lower) |
| bus_din | input | 16 | External read data |
| wait_n | input | 1 | Active-low external wait request |
| breq_n | input | 1 | Active-low bus request from an external master |
| back_n | output | 1 | Active-low bus grant to the external master |

## Verification
A request raised before clock edge E puts the first strobe state on the bus in the cycle right after E. The strobes then stay low for 2+N cycles, plus one cycle for each pin wait, and req_done with its read data follows in the cycle after the last strobe cycle. The bench therefore does not check an access at a fixed cycle. It samples on every falling edge from the request until req_done, counts the as_n-low samples, and records the chip selects, strobes, lane enables and write data it sees during them. The grant is checked one falling edge after the change in breq_n. wait_n is released at a falling edge, once a chosen number of strobe samples has been counted, so the number of added states is known in advance.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    parameter int ADDR_W    = 24;
    parameter int AREA_W    = 3;
    parameter int NUM_AREAS = 1 << AREA_W;
    parameter int WAIT_W    = 2;
    parameter int DATA_W    = 16;
    parameter int BYTE_W    = 8;
    parameter int LANES     = DATA_W / BYTE_W;
    parameter int CFG_SEL_W = 2;

    localparam logic [CFG_SEL_W-1:0] SEL_WIDTH = 2'd0;
    localparam logic [CFG_SEL_W-1:0] SEL_WAIT  = 2'd1;
    localparam logic [CFG_SEL_W-1:0] SEL_PINW  = 2'd2;

    typedef logic [AREA_W-1:0] area_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_T1,
        ST_TW,
        ST_T2,
        ST_REL
    } bus_state_t;

    typedef struct packed {
        area_t             area;
        logic              wide;
        logic [WAIT_W-1:0] waits;
        logic              pin_wait;
    } area_attr_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              write;
        logic              word;
        logic [DATA_W-1:0] wdata;
    } access_t;

    // Bit 1: upper lane (D15..D8), bit 0: lower lane (D7..D0)
    function automatic logic [LANES-1:0] lane_mask(input logic wide,
                                                   input logic word,
                                                   input logic odd);
        if (!wide)
            return 2'b10;
        else if (word && !odd)
            return 2'b11;
        else if (odd)
            return 2'b01;
        else
            return 2'b10;
    endfunction

    function automatic logic [DATA_W-1:0] place_wdata(input logic [LANES-1:0] lanes,
                                                      input logic [DATA_W-1:0] wd);
        case (lanes)
            2'b11:   return wd;
            2'b01:   return {{BYTE_W{1'b0}}, wd[BYTE_W-1:0]};
            default: return {wd[BYTE_W-1:0], {BYTE_W{1'b0}}};
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] pick_rdata(input logic [LANES-1:0] lanes,
                                                     input logic [DATA_W-1:0] din);
        case (lanes)
            2'b11:   return din;
            2'b01:   return {{BYTE_W{1'b0}}, din[BYTE_W-1:0]};
            default: return {{BYTE_W{1'b0}}, din[DATA_W-1:BYTE_W]};
        endcase
    endfunction

endpackage

// File: rtl/xbus_cfg_regs.sv
module xbus_cfg_regs
    import xbus_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cfg_we,
    input  logic [CFG_SEL_W-1:0]        cfg_sel,
    input  logic [DATA_W-1:0]           cfg_wdata,
    output logic [NUM_AREAS-1:0]        width_bits,
    output logic [NUM_AREAS*WAIT_W-1:0] wait_bits,
    output logic [NUM_AREAS-1:0]        pinw_bits
);

    always_ff @(posedge clk) begin
        if (rst) begin
            width_bits <= '0;
            wait_bits  <= '1;
            pinw_bits  <= '0;
        end else if (cfg_we) begin
            case (cfg_sel)
                SEL_WIDTH: width_bits <= cfg_wdata[NUM_AREAS-1:0];
                SEL_WAIT:  wait_bits  <= cfg_wdata[NUM_AREAS*WAIT_W-1:0];
                SEL_PINW:  pinw_bits  <= cfg_wdata[NUM_AREAS-1:0];
                default: ;
            endcase
        end
    end

    AST_UNUSED_SEL_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_sel == 2'd3) |=> ($stable(width_bits) && $stable(wait_bits) && $stable(pinw_bits))); // R11

endmodule

// File: rtl/xbus_area_decode.sv
module xbus_area_decode
    import xbus_pkg::*;
(
    input  logic [ADDR_W-1:0]           addr,
    input  logic [NUM_AREAS-1:0]        width_bits,
    input  logic [NUM_AREAS*WAIT_W-1:0] wait_bits,
    input  logic [NUM_AREAS-1:0]        pinw_bits,
    output area_attr_t                  attr
);

    area_t area;

    always_comb begin
        area          = addr[ADDR_W-1 -: AREA_W];
        attr.area     = area;
        attr.wide     = width_bits[area];
        attr.waits    = wait_bits[area*WAIT_W +: WAIT_W];
        attr.pin_wait = pinw_bits[area];
    end

endmodule

// File: rtl/xbus_cycle_fsm.sv
module xbus_cycle_fsm
    import xbus_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  access_t              req,
    input  area_attr_t           attr_in,
    output logic                 req_done,
    output logic [DATA_W-1:0]    req_rdata,
    output logic [NUM_AREAS-1:0] cs_n,
    output logic                 as_n,
    output logic                 rd_n,
    output logic                 hwr_n,
    output logic                 lwr_n,
    output logic                 ctl_oe,
    output logic [ADDR_W-1:0]    bus_addr,
    output logic                 addr_oe,
    output logic [DATA_W-1:0]    bus_dout,
    output logic [LANES-1:0]     dout_oe,
    input  logic [DATA_W-1:0]    bus_din,
    input  logic                 wait_n,
    input  logic                 breq_n,
    output logic                 back_n
);

    bus_state_t        state;
    access_t           acc_q;
    area_attr_t        attr_q;
    logic [WAIT_W-1:0] wcnt;
    logic              done_q;
    logic [DATA_W-1:0] rdata_q;
    logic              in_cyc;
    logic [LANES-1:0]  lanes;

    assign lanes  = lane_mask(attr_q.wide, acc_q.word, acc_q.addr[0]);
    assign in_cyc = (state == ST_T1) || (state == ST_TW) || (state == ST_T2);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            acc_q   <= '0;
            attr_q  <= '0;
            wcnt    <= '0;
            done_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (!breq_n) begin
                        state <= ST_REL;
                    end else if (req_valid && !done_q) begin
                        state  <= ST_T1;
                        acc_q  <= req;
                        attr_q <= attr_in;
                        wcnt   <= attr_in.waits;
                    end
                end
                ST_T1, ST_TW: begin
                    if (wcnt != '0) begin
                        state <= ST_TW;
                        wcnt  <= wcnt - 1'b1;
                    end else if (attr_q.pin_wait && !wait_n) begin
                        state <= ST_TW;
                    end else begin
                        state <= ST_T2;
                    end
                end
                ST_T2: begin
                    state   <= ST_IDLE;
                    done_q  <= 1'b1;
                    rdata_q <= pick_rdata(lanes, bus_din);
                end
                ST_REL: begin
                    if (breq_n)
                        state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < NUM_AREAS; gi++) begin : g_cs
            assign cs_n[gi] = !(in_cyc && (attr_q.area == area_t'(gi)));
        end
    endgenerate

    assign as_n      = !in_cyc;
    assign rd_n      = !(in_cyc && !acc_q.write);
    assign hwr_n     = !(in_cyc && acc_q.write && lanes[1]);
    assign lwr_n     = !(in_cyc && acc_q.write && lanes[0]);
    assign ctl_oe    = (state != ST_REL);
    assign addr_oe   = (state != ST_REL);
    assign back_n    = (state != ST_REL);
    assign bus_addr  = acc_q.addr;
    assign bus_dout  = place_wdata(lanes, acc_q.wdata);
    assign dout_oe   = (in_cyc && acc_q.write) ? lanes : '0;
    assign req_done  = done_q;
    assign req_rdata = rdata_q;

    AST_ONE_CS: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~cs_n)); // R1
    AST_CS_WITH_AS: assert property (@(posedge clk) disable iff (rst)
        (!as_n) |-> (cs_n != '1)); // R2
    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !(hwr_n && lwr_n))); // R2
    AST_LWR_NEEDS_WIDE: assert property (@(posedge clk) disable iff (rst)
        (!lwr_n) |-> attr_q.wide); // R4
    AST_WAITS_DRAINED: assert property (@(posedge clk) disable iff (rst)
        (state == ST_T2) |-> (wcnt == '0)); // R5
    AST_RELEASE_HIZ: assert property (@(posedge clk) disable iff (rst)
        (!back_n) |-> (!ctl_oe && !addr_oe && dout_oe == '0)); // R8
    AST_GRANT_AFTER_ACCESS: assert property (@(posedge clk) disable iff (rst)
        $fell(back_n) |-> $past(as_n)); // R8
    AST_NO_STROBE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (!back_n) |-> (as_n && cs_n == '1)); // R9

endmodule

// File: rtl/xbus_area_ctrl.sv
module xbus_area_ctrl
    import xbus_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic                 req_word,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic                 req_done,
    output logic [DATA_W-1:0]    req_rdata,
    input  logic                 cfg_we,
    input  logic [CFG_SEL_W-1:0] cfg_sel,
    input  logic [DATA_W-1:0]    cfg_wdata,
    output logic [NUM_AREAS-1:0] cs_n,
    output logic                 as_n,
    output logic                 rd_n,
    output logic                 hwr_n,
    output logic                 lwr_n,
    output logic                 ctl_oe,
    output logic [ADDR_W-1:0]    bus_addr,
    output logic                 addr_oe,
    output logic [DATA_W-1:0]    bus_dout,
    output logic [LANES-1:0]     dout_oe,
    input  logic [DATA_W-1:0]    bus_din,
    input  logic                 wait_n,
    input  logic                 breq_n,
    output logic                 back_n
);

    logic [NUM_AREAS-1:0]        width_bits;
    logic [NUM_AREAS*WAIT_W-1:0] wait_bits;
    logic [NUM_AREAS-1:0]        pinw_bits;
    area_attr_t                  attr;
    access_t                     req;

    assign req.addr  = req_addr;
    assign req.write = req_write;
    assign req.word  = req_word;
    assign req.wdata = req_wdata;

    xbus_cfg_regs u_cfg (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .width_bits (width_bits),
        .wait_bits  (wait_bits),
        .pinw_bits  (pinw_bits)
    );

    xbus_area_decode u_dec (
        .addr       (req_addr),
        .width_bits (width_bits),
        .wait_bits  (wait_bits),
        .pinw_bits  (pinw_bits),
        .attr       (attr)
    );

    xbus_cycle_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req       (req),
        .attr_in   (attr),
        .req_done  (req_done),
        .req_rdata (req_rdata),
        .cs_n      (cs_n),
        .as_n      (as_n),
        .rd_n      (rd_n),
        .hwr_n     (hwr_n),
        .lwr_n     (lwr_n),
        .ctl_oe    (ctl_oe),
        .bus_addr  (bus_addr),
        .addr_oe   (addr_oe),
        .bus_dout  (bus_dout),
        .dout_oe   (dout_oe),
        .bus_din   (bus_din),
        .wait_n    (wait_n),
        .breq_n    (breq_n),
        .back_n    (back_n)
    );

endmodule

// File: tb/xbus_area_ctrl_test.sv
module xbus_area_ctrl_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write, req_word;
    logic [23:0] req_addr;
    logic [15:0] req_wdata;
    logic        req_done;
    logic [15:0] req_rdata;
    logic        cfg_we;
    logic [1:0]  cfg_sel;
    logic [15:0] cfg_wdata;
    logic [7:0]  cs_n;
    logic        as_n, rd_n, hwr_n, lwr_n, ctl_oe, addr_oe, back_n;
    logic [23:0] bus_addr;
    logic [15:0] bus_dout;
    logic [1:0]  dout_oe;
    logic [15:0] bus_din;
    logic        wait_n, breq_n;

    int checks = 0;
    int fails  = 0;

    // observations of the last access
    int          o_len;
    logic [7:0]  o_cs;
    logic        o_rd, o_hwr, o_lwr;
    logic [1:0]  o_oe;
    logic [15:0] o_dout;
    logic [15:0] o_rdata;
    logic        o_done;

    xbus_area_ctrl uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_done(req_done), .req_rdata(req_rdata), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cs_n(cs_n), .as_n(as_n),
        .rd_n(rd_n), .hwr_n(hwr_n), .lwr_n(lwr_n), .ctl_oe(ctl_oe),
        .bus_addr(bus_addr), .addr_oe(addr_oe), .bus_dout(bus_dout),
        .dout_oe(dout_oe), .bus_din(bus_din), .wait_n(wait_n),
        .breq_n(breq_n), .back_n(back_n)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [15:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // release_after: once this many as_n-low samples are seen, wait_n goes high (0 = untouched)
    task automatic access(input logic wr, input logic wd, input logic [23:0] a,
                          input logic [15:0] d, input int release_after);
        int guard;
        o_len = 0; o_cs = 8'hFF; o_rd = 1'b0; o_hwr = 1'b0; o_lwr = 1'b0;
        o_oe = 2'b00; o_dout = 16'h0; o_done = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_word = wd; req_addr = a; req_wdata = d;
        guard = 0;
        while (!o_done && guard < 100) begin
            @(negedge clk);
            guard++;
            if (!as_n) begin
                o_len++;
                o_cs &= cs_n;
                o_rd  |= !rd_n;
                o_hwr |= !hwr_n;
                o_lwr |= !lwr_n;
                o_oe  |= dout_oe;
                if (dout_oe != 2'b00) o_dout = bus_dout;
                if (release_after != 0 && o_len == release_after) wait_n = 1'b1;
            end
            if (req_done) begin
                o_done  = 1'b1;
                o_rdata = req_rdata;
            end
        end
        req_valid = 1'b0;
        check("R7 done seen", {31'b0, o_done}, 32'd1);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R10 cs_n idle", {24'b0, cs_n}, 32'hFF);
        check("R10 strobes idle", {28'b0, as_n, rd_n, hwr_n, lwr_n}, 32'hF);
        check("R10 grant idle", {29'b0, back_n, ctl_oe, addr_oe}, 32'h7);
    endtask

    task automatic t_default_read;
        bus_din = 16'hA55A;
        access(1'b0, 1'b1, 24'h000002, 16'h0, 0);
        check("R10 R5 default 3 waits", o_len, 5);
        check("R1 cs area0", {24'b0, o_cs}, 32'hFE);
        check("R2 rd only", {29'b0, o_rd, o_hwr, o_lwr}, 32'h4);
        check("R7 R10 8-bit read lane", {16'b0, o_rdata}, 32'h00A5);
    endtask

    task automatic t_word_write;
        access(1'b1, 1'b1, 24'h200010, 16'hBEEF, 0);
        check("R5 zero waits", o_len, 2);
        check("R1 cs area1", {24'b0, o_cs}, 32'hFD);
        check("R3 both strobes", {29'b0, o_rd, o_hwr, o_lwr}, 32'h3);
        check("R3 lanes", {30'b0, o_oe}, 32'h3);
        check("R3 data", {16'b0, o_dout}, 32'hBEEF);
    endtask

    task automatic t_byte_writes;
        access(1'b1, 1'b0, 24'h400004, 16'h1234, 0);
        check("R5 one wait", o_len, 3);
        check("R4 even byte hwr", {30'b0, o_hwr, o_lwr}, 32'h2);
        check("R4 even byte data", {14'b0, o_oe, o_dout}, {14'b0, 2'b10, 16'h3400});
        access(1'b1, 1'b0, 24'h400005, 16'h1234, 0);
        check("R4 odd byte lwr", {30'b0, o_hwr, o_lwr}, 32'h1);
        check("R4 odd byte data", {14'b0, o_oe, o_dout}, {14'b0, 2'b01, 16'h0034});
        access(1'b1, 1'b1, 24'h400007, 16'h5678, 0);
        check("R4 odd word lwr", {30'b0, o_hwr, o_lwr}, 32'h1);
    endtask

    task automatic t_reads_wide;
        bus_din = 16'hC3E7;
        access(1'b0, 1'b1, 24'h3FFFFE, 16'h0, 0);
        check("R7 word read", {16'b0, o_rdata}, 32'hC3E7);
        check("R1 cs area1 top", {24'b0, o_cs}, 32'hFD);
        access(1'b0, 1'b0, 24'h200001, 16'h0, 0);
        check("R7 odd byte read", {16'b0, o_rdata}, 32'h00E7);
        access(1'b0, 1'b0, 24'h200000, 16'h0, 0);
        check("R7 even byte read", {16'b0, o_rdata}, 32'h00C3);
    endtask

    task automatic t_narrow_area7;
        access(1'b1, 1'b1, 24'hE00001, 16'hAB12, 0);
        check("R1 cs area7", {24'b0, o_cs}, 32'h7F);
        check("R4 8-bit hwr only", {30'b0, o_hwr, o_lwr}, 32'h2);
        check("R4 8-bit data upper", {14'b0, o_oe, o_dout}, {14'b0, 2'b10, 16'h1200});
        check("R5 area7 default waits", o_len, 5);
    endtask

    task automatic t_pin_wait;
        wait_n = 1'b0;
        access(1'b0, 1'b1, 24'h600000, 16'h0, 6);
        check("R6 pin wait stretches", o_len, 7);
        wait_n = 1'b0;
        access(1'b0, 1'b1, 24'h000000, 16'h0, 0);
        wait_n = 1'b1;
        check("R6 pin wait ignored when off", o_len, 5);
    endtask

    task automatic t_unused_sel;
        cfg_write(2'd3, 16'h0000);
        access(1'b1, 1'b0, 24'h400005, 16'h0099, 0);
        check("R11 sel3 waits kept", o_len, 3);
        check("R11 sel3 width kept", {30'b0, o_hwr, o_lwr}, 32'h1);
    endtask

    task automatic t_release_idle;
        int seen;
        @(negedge clk);
        breq_n = 1'b0;
        @(negedge clk);
        check("R8 grant", {31'b0, back_n}, 32'd0);
        check("R8 hi-z", {29'b0, ctl_oe, addr_oe, |dout_oe}, 32'd0);
        req_valid = 1'b1; req_write = 1'b0; req_word = 1'b1; req_addr = 24'h200000;
        seen = 0;
        repeat (4) begin
            @(negedge clk);
            if (!as_n || cs_n != 8'hFF || req_done) seen++;
        end
        check("R9 stalled while released", seen, 0);
        breq_n = 1'b1;
        @(negedge clk);
        check("R9 grant withdrawn", {30'b0, back_n, as_n}, 32'h3);
        @(negedge clk);
        check("R9 stalled request runs", {31'b0, as_n}, 32'd0);
        while (!req_done) @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic t_release_busy;
        int early;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_word = 1'b1; req_addr = 24'h000000;
        @(negedge clk);
        @(negedge clk);
        breq_n = 1'b0;
        early = 0;
        while (!req_done) begin
            @(negedge clk);
            if (!back_n && !req_done) early++;
        end
        req_valid = 1'b0;
        check("R8 grant waits for access", early, 0);
        @(negedge clk);
        check("R8 grant after access", {31'b0, back_n}, 32'd0);
        breq_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                fails++;
                $display("FAIL watchdog actual=%0d expected=done", cyc);
                $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_word = 1'b0;
        req_addr = '0; req_wdata = '0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
        bus_din = '0; wait_n = 1'b1; breq_n = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_default_read();
        cfg_write(2'd0, 16'h0006);              // areas 1,2 16-bit
        cfg_write(2'd1, 16'hFFD3);              // area1=0, area2=1, others 3
        cfg_write(2'd2, 16'h0008);              // pin wait on area 3
        t_word_write();
        t_byte_writes();
        t_reads_wide();
        t_narrow_area7();
        t_pin_wait();
        t_unused_sel();
        t_release_idle();
        t_release_busy();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule